// File: doc/BRIEF.md
# Non-Blocking Read-Only Cache Front End

This block sits between a set of requesters and a slower memory level. It combines a set-associative tag array with a table of outstanding misses, so that a miss does not stall later requests. Each read request carries a byte address and an identifier. In the same cycle the block answers with one of three codes. HIT means the line is present. MISS means the request was accepted and will complete later. FAIL means the request was refused and must be retried.

A first miss to a block claims a miss-table entry and is placed in a small queue toward memory. The queue presents its head to memory and gives up one entry per cycle while the memory side is not full. Further misses to a block already outstanding join that block's entry and are not queued again. When memory returns a fill tagged with the identifier of the first miss, the line becomes valid. The entry is then marked ready, and its identifiers are handed back one per pop on the ready port, in the order they were accepted. A flush input invalidates every line at once. The block holds no data storage and performs no writes.

Top module: `rofe_top`

## Requirements
- R1: A request whose block is present in a valid line gets code 0 (HIT) in the same cycle. It puts nothing on the memory port and makes nothing ready.
- R2: A first miss that is accepted gets code 1 (MISS). It appends one queue entry, which the memory port shows as the block address (req_addr above the low OFF_W offset bits) together with the request's identifier.
- R3: A miss to a block that already has an outstanding entry holding fewer than MERGE_MAX identifiers gets MISS and joins that entry without being queued. If the entry already holds MERGE_MAX identifiers, the miss gets code 2 (FAIL).
- R4: A first miss gets FAIL when every miss-table entry is busy or the queue already holds MQ_DEPTH entries. A refused request leaves the queue unchanged. The same request is accepted once space returns.
- R5: mem_req_valid is low after reset. The queue head stays unchanged while mem_full is high. While mem_full is low, one entry per cycle leaves in arrival order.
- R6: A fill whose fill_id equals the first identifier of an outstanding entry makes that line valid, so later requests to it get HIT, and marks the entry ready. A request to the same block in the fill cycle joins the entry.
- R7: With allocate-on-miss, an accepted first miss reserves a way until its fill arrives. A first miss to a new block in a set whose ways are all reserved gets FAIL.
- R8: A flush pulse invalidates all lines, so a block that hit before the flush misses after it.
- R9: The victim way is the lowest invalid way. If no way is invalid, a per-set round-robin pointer selects among the valid ways, and the pointer moves past each evicted way.
- R10: rdy_valid is low after reset and whenever no entry is ready. A ready entry shows its identifiers in acceptance order, rdy_pop removes one per cycle, and the entry is freed after its last identifier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Byte address of the request |
| req_id | input | ID_W | Identifier of the request |
| resp_status | output | 2 | 0 HIT, 1 MISS, 2 FAIL; meaningful while req_valid is high |
| mem_full | input | 1 | Memory side cannot take a request this cycle |
| mem_req_valid | output | 1 | Queue head is present |
| mem_req_blk | output | ADDR_W-OFF_W | Block address of the queue head |
| mem_req_id | output | ID_W | Identifier of the queue head |
| fill_valid | input | 1 | Fill response present |
| fill_id | input | ID_W | First-miss identifier of the filled block |
| rdy_valid | output | 1 | A completed miss identifier is available |
| rdy_id | output | ID_W | Identifier of the next completed miss |
| rdy_pop | input | 1 | Remove the identifier shown on rdy_id |
| flush | input | 1 | Invalidate all lines |

## Verification
The delicate overlap is a fill of a block arriving in the same cycle as a new request to that block. The tag probe still sees the reserved line and the miss-table entry is still present, so the request must join the entry rather than start a second memory request. The bench drives fill_valid and req_valid on the same falling edge and expects MISS. It then expects both identifiers to come back in order on the ready port, no second entry on the memory port, and a HIT for the block afterwards. Removing an entry's last identifier in the same cycle as an append to that entry is covered by the same count-based release rule.

// File: rtl/rofe_pkg.sv
package rofe_pkg;
    typedef enum logic [1:0] {
        ST_HIT  = 2'd0,
        ST_MISS = 2'd1,
        ST_FAIL = 2'd2
    } rofe_status_e;

    typedef enum logic [1:0] {
        LN_INVALID  = 2'd0,
        LN_RESERVED = 2'd1,
        LN_VALID    = 2'd2
    } rofe_line_e;
endpackage

// File: rtl/rofe_tags.sv
module rofe_tags
    import rofe_pkg::*;
#(
    parameter int SETS          = 4,
    parameter int WAYS          = 2,
    parameter int BLK_W         = 12,
    parameter bit ALLOC_ON_MISS = 1'b1,
    localparam int WAY_W        = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] probe_blk,
    input  logic             alloc_en,
    input  logic             fill_en,
    input  logic [BLK_W-1:0] fill_blk,
    input  logic [WAY_W-1:0] fill_way,
    input  logic             flush,
    output logic             probe_hit,
    output logic             probe_pend,
    output logic             probe_fail
);
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = BLK_W - SET_W;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][1:0]       st;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAY_W-1:0]           rr;
    } tags_t;

    typedef struct packed {
        logic             found;
        logic             evict;
        logic [WAY_W-1:0] way;
    } victim_t;

    tags_t q, d;

    function automatic victim_t pick(input tags_t s, input logic [SET_W-1:0] set);
        victim_t v;
        v = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!v.found && s.st[set][w] == LN_INVALID) begin
                v.found = 1'b1;
                v.way   = WAY_W'(w);
            end
        end
        for (int k = 0; k < WAYS; k++) begin
            int w2;
            w2 = (int'(s.rr[set]) + k) % WAYS;
            if (!v.found && s.st[set][w2] == LN_VALID) begin
                v.found = 1'b1;
                v.evict = 1'b1;
                v.way   = WAY_W'(w2);
            end
        end
        return v;
    endfunction

    logic [SET_W-1:0] p_set, f_set;
    logic [TAG_W-1:0] p_tag, f_tag;
    victim_t          pv, fv;

    always_comb begin
        p_set      = probe_blk[SET_W-1:0];
        p_tag      = probe_blk[BLK_W-1:SET_W];
        f_set      = fill_blk[SET_W-1:0];
        f_tag      = fill_blk[BLK_W-1:SET_W];
        probe_hit  = 1'b0;
        probe_pend = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (q.tag[p_set][w] == p_tag && q.st[p_set][w] == LN_VALID)    probe_hit  = 1'b1;
            if (q.tag[p_set][w] == p_tag && q.st[p_set][w] == LN_RESERVED) probe_pend = 1'b1;
        end
        pv         = pick(q, p_set);
        fv         = pick(q, f_set);
        probe_fail = ALLOC_ON_MISS && !probe_hit && !probe_pend && !pv.found;

        d = q;
        if (ALLOC_ON_MISS) begin
            if (alloc_en && pv.found) begin
                d.st[p_set][pv.way]  = LN_RESERVED;
                d.tag[p_set][pv.way] = p_tag;
                if (pv.evict) d.rr[p_set] = WAY_W'((int'(pv.way) + 1) % WAYS);
            end
            if (fill_en) begin
                d.st[f_set][fill_way]  = LN_VALID;
                d.tag[f_set][fill_way] = f_tag;
            end
        end else if (fill_en && fv.found) begin
            d.st[f_set][fv.way]  = LN_VALID;
            d.tag[f_set][fv.way] = f_tag;
            if (fv.evict) d.rr[f_set] = WAY_W'((int'(fv.way) + 1) % WAYS);
        end
        if (flush) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    d.st[s][w] = LN_INVALID;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R7: the controller reserves a way only for a block with no line at all
    assert_alloc_fresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> (!probe_hit && !probe_pend && !probe_fail));
endmodule

// File: rtl/rofe_mshr.sv
module rofe_mshr #(
    parameter int ENTRIES = 4,
    parameter int MERGE   = 2,
    parameter int BLK_W   = 12,
    parameter int ID_W    = 4,
    parameter int WAY_W   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] lk_blk,
    input  logic             add_en,
    input  logic [ID_W-1:0]  add_id,
    input  logic [WAY_W-1:0] add_way,
    input  logic             fill_en,
    input  logic [ID_W-1:0]  fill_id,
    input  logic             pop,
    output logic             lk_match,
    output logic             lk_room,
    output logic             fill_hit,
    output logic [BLK_W-1:0] fill_blk,
    output logic [WAY_W-1:0] fill_way,
    output logic             rdy_valid,
    output logic [ID_W-1:0]  rdy_id
);
    localparam int CNT_W = $clog2(MERGE + 1);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic                       valid;
        logic                       ready;
        logic [BLK_W-1:0]           blk;
        logic [ID_W-1:0]            first_id;
        logic [WAY_W-1:0]           way;
        logic [CNT_W-1:0]           cnt;
        logic [MERGE-1:0][ID_W-1:0] ids;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
    } mshr_t;

    mshr_t q, d;
    logic [IDX_W-1:0] midx, fridx, fidx, ridx;
    logic             free;

    always_comb begin
        lk_match = 1'b0; free = 1'b0; fill_hit = 1'b0; rdy_valid = 1'b0;
        midx = '0; fridx = '0; fidx = '0; ridx = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (!lk_match && q.ent[e].valid && q.ent[e].blk == lk_blk) begin
                lk_match = 1'b1; midx = IDX_W'(e);
            end
            if (!free && !q.ent[e].valid) begin
                free = 1'b1; fridx = IDX_W'(e);
            end
            if (!fill_hit && q.ent[e].valid && !q.ent[e].ready && q.ent[e].first_id == fill_id) begin
                fill_hit = 1'b1; fidx = IDX_W'(e);
            end
            if (!rdy_valid && q.ent[e].valid && q.ent[e].ready) begin
                rdy_valid = 1'b1; ridx = IDX_W'(e);
            end
        end
        lk_room  = lk_match ? (int'(q.ent[midx].cnt) < MERGE) : free;
        fill_blk = q.ent[fidx].blk;
        fill_way = q.ent[fidx].way;
        rdy_id   = q.ent[ridx].ids[0];

        d = q;
        if (pop && rdy_valid) begin
            for (int i = 0; i < MERGE - 1; i++)
                d.ent[ridx].ids[i] = q.ent[ridx].ids[i+1];
            d.ent[ridx].cnt = q.ent[ridx].cnt - 1'b1;
        end
        if (add_en && lk_match) begin
            for (int i = 0; i < MERGE; i++)
                if (i == int'(d.ent[midx].cnt)) d.ent[midx].ids[i] = add_id;
            d.ent[midx].cnt = d.ent[midx].cnt + 1'b1;
        end else if (add_en && free) begin
            d.ent[fridx]          = '0;
            d.ent[fridx].valid    = 1'b1;
            d.ent[fridx].blk      = lk_blk;
            d.ent[fridx].first_id = add_id;
            d.ent[fridx].way      = add_way;
            d.ent[fridx].cnt      = CNT_W'(1);
            d.ent[fridx].ids[0]   = add_id;
        end
        if (fill_en && fill_hit) d.ent[fidx].ready = 1'b1;
        for (int e = 0; e < ENTRIES; e++)
            if (d.ent[e].valid && d.ent[e].cnt == '0) d.ent[e].valid = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3: an add reaches the table only when the entry or a free slot has room
    assert_add_has_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
        add_en |-> lk_room);

    // R10: a pop is only issued while an identifier is on offer
    assert_pop_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> rdy_valid);
endmodule

// File: rtl/rofe_missq.sv
module rofe_missq #(
    parameter int DEPTH = 2,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         valid_o,
    output logic         full_o,
    output logic [W-1:0] head_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rd;
        logic [PTR_W-1:0]        wr;
        logic [CNT_W-1:0]        cnt;
    } mq_t;

    mq_t q, d;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        valid_o = (q.cnt != '0);
        full_o  = (int'(q.cnt) == DEPTH);
        head_o  = q.mem[q.rd];
        d = q;
        if (push) begin
            d.mem[q.wr] = push_data;
            d.wr        = nxt(q.wr);
        end
        if (pop) d.rd = nxt(q.rd);
        d.cnt = q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R4: the controller never pushes into a queue at its depth
    assert_mq_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full_o);

    // R5: an entry that is not taken stays at the head unchanged
    assert_head_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != '0 && !pop) |=> (valid_o && $stable(head_o)));
endmodule

// File: rtl/rofe_top.sv
module rofe_top
    import rofe_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int OFF_W         = 4,
    parameter int SETS          = 4,
    parameter int WAYS          = 2,
    parameter int MSHR_ENTRIES  = 4,
    parameter int MERGE_MAX     = 2,
    parameter int MQ_DEPTH      = 2,
    parameter int ID_W          = 4,
    parameter bit ALLOC_ON_MISS = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [ID_W-1:0]         req_id,
    output logic [1:0]              resp_status,
    input  logic                    mem_full,
    output logic                    mem_req_valid,
    output logic [ADDR_W-OFF_W-1:0] mem_req_blk,
    output logic [ID_W-1:0]         mem_req_id,
    input  logic                    fill_valid,
    input  logic [ID_W-1:0]         fill_id,
    output logic                    rdy_valid,
    output logic [ID_W-1:0]         rdy_id,
    input  logic                    rdy_pop,
    input  logic                    flush
);
    localparam int BLK_W = ADDR_W - OFF_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int MQ_W  = ID_W + BLK_W;

    logic [BLK_W-1:0] blk_d;
    logic             t_hit, t_pend, t_fail;
    logic             m_match, m_room, m_fill_hit;
    logic [BLK_W-1:0] m_fill_blk;
    logic [WAY_W-1:0] m_fill_way;
    logic             q_full, q_pop;
    logic [MQ_W-1:0]  q_head;
    logic             first_ok_d, merge_ok_d, alloc_d, add_d, push_d, tfill_d;

    always_comb begin
        blk_d       = req_addr[ADDR_W-1:OFF_W];
        first_ok_d  = !t_hit && !t_fail && !m_match && m_room && !q_full;
        merge_ok_d  = !t_hit && !t_fail && m_match && m_room;
        push_d      = req_valid && first_ok_d;
        add_d       = req_valid && (first_ok_d || merge_ok_d);
        alloc_d     = push_d && !t_pend;
        tfill_d     = fill_valid && m_fill_hit;
        q_pop       = mem_req_valid && !mem_full;
        if (t_hit)                         resp_status = ST_HIT;
        else if (first_ok_d || merge_ok_d) resp_status = ST_MISS;
        else                               resp_status = ST_FAIL;
        mem_req_id  = q_head[MQ_W-1:BLK_W];
        mem_req_blk = q_head[BLK_W-1:0];
    end

    rofe_tags #(
        .SETS(SETS), .WAYS(WAYS), .BLK_W(BLK_W), .ALLOC_ON_MISS(ALLOC_ON_MISS)
    ) u_tags (
        .clk(clk), .rst_n(rst_n), .probe_blk(blk_d), .alloc_en(alloc_d),
        .fill_en(tfill_d), .fill_blk(m_fill_blk), .fill_way(m_fill_way), .flush(flush),
        .probe_hit(t_hit), .probe_pend(t_pend), .probe_fail(t_fail)
    );

    // The way a first miss will take is recomputed by the tag array in the
    // same cycle; the table records it through the fill index path below.
    logic [WAY_W-1:0] way_d;
    always_comb begin
        way_d = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (u_tags.q.st[blk_d[$clog2(SETS)-1:0]][w] == LN_INVALID) way_d = WAY_W'(w);
        end
        if (u_tags.pv.found) way_d = u_tags.pv.way;
    end

    rofe_mshr #(
        .ENTRIES(MSHR_ENTRIES), .MERGE(MERGE_MAX), .BLK_W(BLK_W), .ID_W(ID_W), .WAY_W(WAY_W)
    ) u_mshr (
        .clk(clk), .rst_n(rst_n), .lk_blk(blk_d), .add_en(add_d), .add_id(req_id),
        .add_way(way_d), .fill_en(fill_valid), .fill_id(fill_id), .pop(rdy_pop),
        .lk_match(m_match), .lk_room(m_room), .fill_hit(m_fill_hit),
        .fill_blk(m_fill_blk), .fill_way(m_fill_way), .rdy_valid(rdy_valid), .rdy_id(rdy_id)
    );

    rofe_missq #(
        .DEPTH(MQ_DEPTH), .W(MQ_W)
    ) u_mq (
        .clk(clk), .rst_n(rst_n), .push(push_d), .push_data({req_id, blk_d}),
        .pop(q_pop), .valid_o(mem_req_valid), .full_o(q_full), .head_o(q_head)
    );
endmodule

// File: tb/rofe_top_tb.sv
module rofe_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_id = '0;
    logic [1:0]  resp_status;
    logic        mem_full = 1'b1;
    logic        mem_req_valid;
    logic [11:0] mem_req_blk;
    logic [3:0]  mem_req_id;
    logic        fill_valid = 1'b0;
    logic [3:0]  fill_id = '0;
    logic        rdy_valid;
    logic [3:0]  rdy_id;
    logic        rdy_pop = 1'b0;
    logic        flush = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [1:0] HIT = 2'd0, MISS = 2'd1, FAIL_C = 2'd2;
    localparam logic [15:0] A = 16'h0100, B = 16'h0140, C = 16'h0180;

    always #(CLK_PERIOD/2) clk = ~clk;

    rofe_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_id(req_id),
        .resp_status(resp_status), .mem_full(mem_full), .mem_req_valid(mem_req_valid),
        .mem_req_blk(mem_req_blk), .mem_req_id(mem_req_id), .fill_valid(fill_valid),
        .fill_id(fill_id), .rdy_valid(rdy_valid), .rdy_id(rdy_id), .rdy_pop(rdy_pop), .flush(flush)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; fill_valid = 1'b0; rdy_pop = 1'b0;
        flush = 1'b0; mem_full = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic req(input logic [15:0] a, input logic [3:0] id, input logic [1:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_id = id;
        #1 chk(tag, resp_status, exp);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic drain(input logic [11:0] blk, input logic [3:0] id, input string tag);
        @(negedge clk);
        chk({tag, " valid"}, mem_req_valid, 1);
        chk({tag, " blk"}, mem_req_blk, blk);
        chk({tag, " id"}, mem_req_id, id);
        mem_full = 1'b0;
        @(posedge clk);
        #1 mem_full = 1'b1;
    endtask

    task automatic do_fill(input logic [3:0] id);
        @(negedge clk);
        fill_valid = 1'b1; fill_id = id;
        @(posedge clk);
        #1 fill_valid = 1'b0;
    endtask

    task automatic pop(input logic [3:0] id, input string tag);
        @(negedge clk);
        chk({tag, " rdy_valid"}, rdy_valid, 1);
        chk({tag, " rdy_id"}, rdy_id, id);
        rdy_pop = 1'b1;
        @(posedge clk);
        #1 rdy_pop = 1'b0;
    endtask

    task automatic mem_empty(input string tag);
        @(negedge clk);
        chk({tag, " mem_req_valid"}, mem_req_valid, 0);
    endtask

    task automatic rdy_empty(input string tag);
        @(negedge clk);
        chk({tag, " rdy_valid"}, rdy_valid, 0);
    endtask

    task automatic load(input logic [15:0] a, input logic [3:0] id);
        req(a, id, MISS, "R2 load");
        drain(a[15:4], id, "R5 load drain");
        do_fill(id);
        pop(id, "R10 load pop");
    endtask

    task automatic t_reset();
        do_reset();
        mem_empty("R5 reset");
        rdy_empty("R10 reset");
    endtask

    task automatic t_first_miss();
        do_reset();
        req(A, 4'd1, MISS, "R2 first miss");
        @(negedge clk);
        chk("R2 queued", mem_req_valid, 1);
        chk("R2 blk", mem_req_blk, 12'h010);
        @(negedge clk);
        chk("R5 held valid", mem_req_valid, 1);
        chk("R5 held id", mem_req_id, 1);
        drain(12'h010, 4'd1, "R5 drain");
        mem_empty("R5 after drain");
    endtask

    task automatic t_merge();
        do_reset();
        req(A, 4'd1, MISS, "R2 first");
        req(A + 16'h4, 4'd2, MISS, "R3 merge");
        req(A, 4'd3, FAIL_C, "R3 merge cap");
        drain(12'h010, 4'd1, "R3 one queued");
        mem_empty("R3 merge not queued");
        do_fill(4'd1);
        pop(4'd1, "R10 order first");
        pop(4'd2, "R10 order second");
        rdy_empty("R10 released");
        req(A, 4'd5, HIT, "R1 hit after fill");
        mem_empty("R1 no mem");
        rdy_empty("R1 no ready");
    endtask

    task automatic t_full();
        do_reset();
        req(16'h0100, 4'd1, MISS, "R4 a");
        req(16'h0110, 4'd2, MISS, "R4 b");
        req(16'h0120, 4'd3, FAIL_C, "R4 queue full");
        drain(12'h010, 4'd1, "R4 unchanged head");
        req(16'h0120, 4'd3, MISS, "R4 retry");
        drain(12'h011, 4'd2, "R5 order b");
        req(16'h0130, 4'd4, MISS, "R4 d");
        drain(12'h012, 4'd3, "R5 order c");
        drain(12'h013, 4'd4, "R5 order d");
        req(16'h0200, 4'd5, FAIL_C, "R4 mshr full");
        mem_empty("R4 refused not queued");
        do_fill(4'd1);
        pop(4'd1, "R10 free slot");
        req(16'h0200, 4'd5, MISS, "R4 slot returned");
        drain(12'h020, 4'd5, "R4 queued after return");
    endtask

    task automatic t_reserve();
        do_reset();
        req(A, 4'd1, MISS, "R7 a");
        drain(12'h010, 4'd1, "R7 a drain");
        req(B, 4'd2, MISS, "R7 b");
        drain(12'h014, 4'd2, "R7 b drain");
        req(C, 4'd3, FAIL_C, "R7 set reserved");
        do_fill(4'd1);
        pop(4'd1, "R6 a ready");
        req(C, 4'd3, MISS, "R7 after fill");
        req(A, 4'd4, FAIL_C, "R7 again reserved");
    endtask

    task automatic t_replace();
        do_reset();
        load(A, 4'd1);
        load(B, 4'd2);
        req(A, 4'd6, HIT, "R9 a hit");
        req(B, 4'd7, HIT, "R9 b hit");
        load(C, 4'd3);
        req(B, 4'd8, HIT, "R9 b kept");
        req(C, 4'd9, HIT, "R9 c present");
        req(A, 4'd4, MISS, "R9 a evicted");
    endtask

    task automatic t_flush();
        do_reset();
        load(A, 4'd1);
        req(A, 4'd2, HIT, "R8 before flush");
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        #1 flush = 1'b0;
        req(A, 4'd3, MISS, "R8 after flush");
        drain(12'h010, 4'd3, "R8 refetch");
    endtask

    task automatic t_collide();
        do_reset();
        req(A, 4'd1, MISS, "R6 first");
        drain(12'h010, 4'd1, "R6 drain");
        @(negedge clk);
        req_valid = 1'b1; req_addr = A + 16'h8; req_id = 4'd2;
        fill_valid = 1'b1; fill_id = 4'd1;
        #1 chk("R6 merge in fill cycle", resp_status, MISS);
        @(posedge clk);
        #1 begin req_valid = 1'b0; fill_valid = 1'b0; end
        mem_empty("R6 no second request");
        pop(4'd1, "R6 pop first");
        pop(4'd2, "R6 pop merged");
        rdy_empty("R10 drained");
        req(A, 4'd3, HIT, "R6 line valid");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_first_miss();
        t_merge();
        t_full();
        t_reserve();
        t_replace();
        t_flush();
        t_collide();
        summary();
    end
endmodule